// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the software-visible configuration and status state of a four-bank SDRAM controller. Software reaches every register through two ports. A write to the offset port stores an internal register offset. The data port then reads or writes the register at that stored offset. The register set covers the following:

- two bus-error status words, which hardware sets and software clears;
- an error address word;
- a global configuration word whose top bit enables the controller;
- a read-only status word;
- refresh, timing and power-management words;
- ECC configuration and ECC error status words;
- one configuration word per bank.

From these registers the block drives, for each bank, a decoded base address, a size and an "on" flag. It also drives a per-bank hit signal for an incoming memory address, and an ECC error interrupt. The command sequencer, refresh engine and data path live elsewhere and consume these outputs.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write on the offset port stores the offset. Data-port writes take effect at the next clock edge at the stored offset. `dat_rdata` combinationally shows the register at the stored offset. Offsets: 0x00 and 0x08 are error status 0/1, 0x10 is error address, 0x20 is configuration, 0x24 is status, 0x30 is refresh, 0x34 is power, 0x40+4*i is bank i (i = 0..3), 0x80 is timing, 0x94 is ECC configuration and 0x98 is ECC error status.
- R2: After reset, configuration reads 0x00800000, refresh reads 0x05F00000, timing reads 0x00854009, power reads 0x07C00000, and every other register reads 0. `ecc_irq` is 0 after reset.
- R3: A write to either error status word clears the bits written as one. A bit set on `err_set0` or `err_set1` in the same cycle wins and reads as one.
- R4: The status word cannot be written; a write at 0x24 leaves it unchanged.
- R5: A configuration write that takes bit 31 from 0 to 1 clears status bit 31. A write that takes it from 1 to 0 sets status bit 31.
- R6: Every configuration write copies data bit 30 into status bit 30.
- R7: Stored values are masked. Refresh keeps bits under 0x3FF80000, timing under 0x018FC01F, ECC configuration under 0x00F00000 and bank words under 0xFFDEE001. Power stores (data AND 0xF8000000) OR 0x07C00000. Error address, configuration and ECC error status store the full word.
- R8: For bank i, `bank_base[i]` is the bank word AND 0xFF800000. `bank_size[i]` is 4 MiB shifted left by bits 19:17, or 0 when that field is 7. `bank_on[i]` is configuration bit 31 AND bank bit 0.
- R9: `bank_hit[i]` is 1 exactly when `bank_on[i]` is 1 and `bank_base[i]` <= `mem_addr` < `bank_base[i]` + `bank_size[i]`.
- R10: `ecc_irq` rises after a write of a nonzero value to ECC error status, and falls after a write of zero.
- R11: Any other offset, including 0x04 and the offsets between the listed ones, reads 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ofs_we | input | 1 | Offset port write strobe |
| ofs_wdata | input | OFS_W | Offset to store |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 32 | Data port write value |
| dat_rdata | output | 32 | Register at the stored offset |
| err_set0 | input | 32 | Bits to set in error status 0 |
| err_set1 | input | 32 | Bits to set in error status 1 |
| mem_addr | input | 32 | Address decoded against the banks |
| bank_base | output | NBANK x 32 | Decoded bank base addresses |
| bank_size | output | NBANK x 32 | Decoded bank sizes in bytes |
| bank_on | output | NBANK | Bank valid and controller enabled |
| bank_hit | output | NBANK | `mem_addr` falls inside the bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The bench builds the block with its default parameters: four banks and an 8-bit offset. These defaults put all four bank words and the full offset map in reach, including the unassigned offsets between registers. Random writes cover every size field value, including the invalid value 7, with the enable bit toggling at random. Each bank is then probed at its first and last byte and just outside both ends.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

    localparam int unsigned REG_W = 32;

    // Register offsets (software-visible map)
    localparam logic [15:0] OFS_ERR0  = 16'h0000;
    localparam logic [15:0] OFS_ERR1  = 16'h0008;
    localparam logic [15:0] OFS_EADR  = 16'h0010;
    localparam logic [15:0] OFS_CFG   = 16'h0020;
    localparam logic [15:0] OFS_STAT  = 16'h0024;
    localparam logic [15:0] OFS_RFSH  = 16'h0030;
    localparam logic [15:0] OFS_PWR   = 16'h0034;
    localparam logic [15:0] OFS_BANK0 = 16'h0040;
    localparam logic [15:0] OFS_TIM   = 16'h0080;
    localparam logic [15:0] OFS_ECCC  = 16'h0094;
    localparam logic [15:0] OFS_ECCS  = 16'h0098;

    // Write masks and forced bits
    localparam logic [REG_W-1:0] MASK_RFSH  = 32'h3FF8_0000;
    localparam logic [REG_W-1:0] MASK_TIM   = 32'h018F_C01F;
    localparam logic [REG_W-1:0] MASK_ECCC  = 32'h00F0_0000;
    localparam logic [REG_W-1:0] MASK_BANK  = 32'hFFDE_E001;
    localparam logic [REG_W-1:0] MASK_PWR   = 32'hF800_0000;
    localparam logic [REG_W-1:0] FORCE_PWR  = 32'h07C0_0000;
    localparam logic [REG_W-1:0] MASK_BASE  = 32'hFF80_0000;

    // Reset values
    localparam logic [REG_W-1:0] RST_CFG  = 32'h0080_0000;
    localparam logic [REG_W-1:0] RST_RFSH = 32'h05F0_0000;
    localparam logic [REG_W-1:0] RST_TIM  = 32'h0085_4009;
    localparam logic [REG_W-1:0] RST_PWR  = 32'h07C0_0000;

    localparam int unsigned BIT_EN   = 31;
    localparam int unsigned BIT_SELF = 30;
    localparam int unsigned SZ_LO    = 17;
    localparam int unsigned SZ_W     = 3;
    localparam logic [REG_W-1:0] UNIT_SIZE = 32'h0040_0000;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ERR0,
        SEL_ERR1,
        SEL_EADR,
        SEL_CFG,
        SEL_STAT,
        SEL_RFSH,
        SEL_PWR,
        SEL_BANK,
        SEL_TIM,
        SEL_ECCC,
        SEL_ECCS
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e    sel;
        logic [1:0]  bank;
    } reg_dec_t;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] size;
        logic             on;
    } bank_dec_t;

    function automatic reg_dec_t decode_ofs(input logic [15:0] ofs, input int unsigned nbank);
        reg_dec_t d;
        d.sel  = SEL_NONE;
        d.bank = 2'd0;
        case (ofs)
            OFS_ERR0: d.sel = SEL_ERR0;
            OFS_ERR1: d.sel = SEL_ERR1;
            OFS_EADR: d.sel = SEL_EADR;
            OFS_CFG:  d.sel = SEL_CFG;
            OFS_STAT: d.sel = SEL_STAT;
            OFS_RFSH: d.sel = SEL_RFSH;
            OFS_PWR:  d.sel = SEL_PWR;
            OFS_TIM:  d.sel = SEL_TIM;
            OFS_ECCC: d.sel = SEL_ECCC;
            OFS_ECCS: d.sel = SEL_ECCS;
            default: begin
                if (ofs[15:4] == OFS_BANK0[15:4] && ofs[1:0] == 2'b00
                    && 32'(ofs[3:2]) < nbank) begin
                    d.sel  = SEL_BANK;
                    d.bank = ofs[3:2];
                end
            end
        endcase
        return d;
    endfunction

    function automatic logic [REG_W-1:0] size_of_field(input logic [SZ_W-1:0] f);
        if (f == '1) return '0;
        return UNIT_SIZE << f;
    endfunction

endpackage

// File: rtl/sdram_cfg_ctrl.sv
module sdram_cfg_ctrl
    import sdram_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             rfsh_we,
    input  logic             tim_we,
    input  logic             pwr_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_q,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] rfsh_q,
    output logic [REG_W-1:0] tim_q,
    output logic [REG_W-1:0] pwr_q,
    output logic             ctrl_en
);

    logic en_rise, en_fall;

    always_comb begin
        en_rise = cfg_we && !cfg_q[BIT_EN] &&  wdata[BIT_EN];
        en_fall = cfg_we &&  cfg_q[BIT_EN] && !wdata[BIT_EN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= RST_CFG;
            stat_q <= '0;
            rfsh_q <= RST_RFSH;
            tim_q  <= RST_TIM;
            pwr_q  <= RST_PWR;
        end else begin
            if (cfg_we) begin
                cfg_q            <= wdata;
                stat_q[BIT_SELF] <= wdata[BIT_SELF];
            end
            if (en_rise) stat_q[BIT_EN] <= 1'b0;
            if (en_fall) stat_q[BIT_EN] <= 1'b1;
            if (rfsh_we) rfsh_q <= wdata & MASK_RFSH;
            if (tim_we)  tim_q  <= wdata & MASK_TIM;
            if (pwr_we)  pwr_q  <= (wdata & MASK_PWR) | FORCE_PWR;
        end
    end

    assign ctrl_en = cfg_q[BIT_EN];

    // R4: status only moves on a configuration write
    a_r4_status_only_by_cfg: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(stat_q));

    // R5: enable edges drive status bit 31
    a_r5_enable_clears: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_q[BIT_EN] && wdata[BIT_EN]) |=> !stat_q[BIT_EN]);
    a_r5_disable_sets: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_q[BIT_EN] && !wdata[BIT_EN]) |=> stat_q[BIT_EN]);

    // R6: status bit 30 copies configuration bit 30
    a_r6_self_follow: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> stat_q[BIT_SELF] == $past(wdata[BIT_SELF]));

    // R7: masked and forced fields
    a_r7_pwr_forced: assert property (@(posedge clk) disable iff (rst)
        (pwr_q & ~MASK_PWR) == FORCE_PWR);
    a_r7_rfsh_mask: assert property (@(posedge clk) disable iff (rst)
        (rfsh_q & ~MASK_RFSH) == '0);

endmodule

// File: rtl/sdram_cfg_bank.sv
module sdram_cfg_bank
    import sdram_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             ctrl_en,
    input  logic [REG_W-1:0] addr,
    output logic [REG_W-1:0] bcr_q,
    output bank_dec_t        dec,
    output logic             hit
);

    logic [REG_W-1:0] offset;

    always_ff @(posedge clk) begin
        if (rst)     bcr_q <= '0;
        else if (we) bcr_q <= wdata & MASK_BANK;
    end

    always_comb begin
        dec.base = bcr_q & MASK_BASE;
        dec.size = size_of_field(bcr_q[SZ_LO +: SZ_W]);
        dec.on   = ctrl_en && bcr_q[0];
        offset   = addr - dec.base;
        hit      = dec.on && (addr >= dec.base) && (offset < dec.size);
    end

    // R7: bank word keeps only its defined bits
    a_r7_bank_mask: assert property (@(posedge clk) disable iff (rst)
        (bcr_q & ~MASK_BANK) == '0);

    // R9: a hit needs an enabled controller and a valid bank
    a_r9_hit_needs_on: assert property (@(posedge clk) disable iff (rst)
        hit |-> (ctrl_en && bcr_q[0]));

endmodule

// File: rtl/sdram_cfg_ecc.sv
module sdram_cfg_ecc
    import sdram_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             stat_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] eccc_q,
    output logic [REG_W-1:0] eccs_q,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            eccc_q <= '0;
            eccs_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (cfg_we) eccc_q <= wdata & MASK_ECCC;
            if (stat_we) begin
                eccs_q <= wdata;
                irq    <= (wdata != '0);
            end
        end
    end

    // R10: interrupt level agrees with the stored error status
    a_r10_irq_tracks: assert property (@(posedge clk) disable iff (rst)
        irq == (eccs_q != '0));

    a_r7_eccc_mask: assert property (@(posedge clk) disable iff (rst)
        (eccc_q & ~MASK_ECCC) == '0);

endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned NBANK = 4,
    parameter int unsigned OFS_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ofs_we,
    input  logic [OFS_W-1:0]            ofs_wdata,
    input  logic                        dat_we,
    input  logic [REG_W-1:0]            dat_wdata,
    output logic [REG_W-1:0]            dat_rdata,
    input  logic [REG_W-1:0]            err_set0,
    input  logic [REG_W-1:0]            err_set1,
    input  logic [REG_W-1:0]            mem_addr,
    output logic [NBANK-1:0][REG_W-1:0] bank_base,
    output logic [NBANK-1:0][REG_W-1:0] bank_size,
    output logic [NBANK-1:0]            bank_on,
    output logic [NBANK-1:0]            bank_hit,
    output logic                        ecc_irq
);

    localparam int unsigned BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [OFS_W-1:0] ofs_q;
    reg_dec_t         dec;
    logic [REG_W-1:0] err0_q, err1_q, eadr_q;
    logic [REG_W-1:0] cfg_q, stat_q, rfsh_q, tim_q, pwr_q;
    logic [REG_W-1:0] eccc_q, eccs_q;
    logic             ctrl_en;
    logic [NBANK-1:0][REG_W-1:0] bcr_q;
    logic [NBANK-1:0] bank_we;
    logic             wr_err0, wr_err1, wr_eadr;

    // Offset latch
    always_ff @(posedge clk) begin
        if (rst)         ofs_q <= '0;
        else if (ofs_we) ofs_q <= ofs_wdata;
    end

    always_comb dec = decode_ofs(16'(ofs_q), NBANK);

    always_comb begin
        wr_err0 = dat_we && dec.sel == SEL_ERR0;
        wr_err1 = dat_we && dec.sel == SEL_ERR1;
        wr_eadr = dat_we && dec.sel == SEL_EADR;
    end

    // Bus error capture: hardware sets, software clears by writing ones
    always_ff @(posedge clk) begin
        if (rst) begin
            err0_q <= '0;
            err1_q <= '0;
            eadr_q <= '0;
        end else begin
            err0_q <= (wr_err0 ? (err0_q & ~dat_wdata) : err0_q) | err_set0;
            err1_q <= (wr_err1 ? (err1_q & ~dat_wdata) : err1_q) | err_set1;
            if (wr_eadr) eadr_q <= dat_wdata;
        end
    end

    sdram_cfg_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (dat_we && dec.sel == SEL_CFG),
        .rfsh_we (dat_we && dec.sel == SEL_RFSH),
        .tim_we  (dat_we && dec.sel == SEL_TIM),
        .pwr_we  (dat_we && dec.sel == SEL_PWR),
        .wdata   (dat_wdata),
        .cfg_q   (cfg_q),
        .stat_q  (stat_q),
        .rfsh_q  (rfsh_q),
        .tim_q   (tim_q),
        .pwr_q   (pwr_q),
        .ctrl_en (ctrl_en)
    );

    sdram_cfg_ecc u_ecc (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (dat_we && dec.sel == SEL_ECCC),
        .stat_we (dat_we && dec.sel == SEL_ECCS),
        .wdata   (dat_wdata),
        .eccc_q  (eccc_q),
        .eccs_q  (eccs_q),
        .irq     (ecc_irq)
    );

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
        bank_dec_t bdec;

        assign bank_we[gi] = dat_we && dec.sel == SEL_BANK
                             && dec.bank[BIDX_W-1:0] == BIDX_W'(gi);

        sdram_cfg_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .we      (bank_we[gi]),
            .wdata   (dat_wdata),
            .ctrl_en (ctrl_en),
            .addr    (mem_addr),
            .bcr_q   (bcr_q[gi]),
            .dec     (bdec),
            .hit     (bank_hit[gi])
        );

        assign bank_base[gi] = bdec.base;
        assign bank_size[gi] = bdec.size;
        assign bank_on[gi]   = bdec.on;
    end

    // Read multiplexer
    always_comb begin
        dat_rdata = '0;
        case (dec.sel)
            SEL_ERR0: dat_rdata = err0_q;
            SEL_ERR1: dat_rdata = err1_q;
            SEL_EADR: dat_rdata = eadr_q;
            SEL_CFG:  dat_rdata = cfg_q;
            SEL_STAT: dat_rdata = stat_q;
            SEL_RFSH: dat_rdata = rfsh_q;
            SEL_PWR:  dat_rdata = pwr_q;
            SEL_TIM:  dat_rdata = tim_q;
            SEL_ECCC: dat_rdata = eccc_q;
            SEL_ECCS: dat_rdata = eccs_q;
            SEL_BANK: dat_rdata = bcr_q[dec.bank[BIDX_W-1:0]];
            default:  dat_rdata = '0;
        endcase
    end

    // R3: written ones clear unless hardware sets them in the same cycle
    a_r3_err0_w1c: assert property (@(posedge clk) disable iff (rst)
        wr_err0 |=> (err0_q & $past(dat_wdata) & ~$past(err_set0)) == '0);
    a_r3_err1_w1c: assert property (@(posedge clk) disable iff (rst)
        wr_err1 |=> (err1_q & $past(dat_wdata) & ~$past(err_set1)) == '0);

    // R11: an unassigned offset never returns data
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (dec.sel == SEL_NONE) |-> dat_rdata == '0);

    // R1: a write to a bank leaves all other bank words alone
    a_r1_one_bank_we: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_we));

endmodule

// File: tb/sdram_cfg_regs_tb.sv
module sdram_cfg_regs_tb;

    localparam int NB = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              ofs_we;
    logic [7:0]        ofs_wdata;
    logic              dat_we;
    logic [31:0]       dat_wdata;
    logic [31:0]       dat_rdata;
    logic [31:0]       err_set0, err_set1;
    logic [31:0]       mem_addr;
    logic [NB-1:0][31:0] bank_base, bank_size;
    logic [NB-1:0]     bank_on, bank_hit;
    logic              ecc_irq;

    always #10 clk = ~clk;

    sdram_cfg_regs #(.NBANK(NB), .OFS_W(8)) u_dut (
        .clk(clk), .rst(rst), .ofs_we(ofs_we), .ofs_wdata(ofs_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .err_set0(err_set0), .err_set1(err_set1), .mem_addr(mem_addr),
        .bank_base(bank_base), .bank_size(bank_size), .bank_on(bank_on),
        .bank_hit(bank_hit), .ecc_irq(ecc_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model
    logic [31:0] m_err0, m_err1, m_eadr, m_cfg, m_stat, m_rfsh, m_pwr, m_tim;
    logic [31:0] m_eccc, m_eccs;
    logic [31:0] m_bank [NB];
    logic        m_irq;

    logic [7:0] ofs_list [16] = '{8'h00, 8'h08, 8'h10, 8'h20, 8'h24, 8'h30, 8'h34,
                                  8'h40, 8'h44, 8'h48, 8'h4C, 8'h80, 8'h94, 8'h98,
                                  8'h04, 8'h42};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_err0 = 0; m_err1 = 0; m_eadr = 0; m_cfg = 32'h0080_0000; m_stat = 0;
        m_rfsh = 32'h05F0_0000; m_pwr = 32'h07C0_0000; m_tim = 32'h0085_4009;
        m_eccc = 0; m_eccs = 0; m_irq = 0;
        for (int i = 0; i < NB; i++) m_bank[i] = 0;
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] o);
        case (o)
            8'h00: return m_err0;
            8'h08: return m_err1;
            8'h10: return m_eadr;
            8'h20: return m_cfg;
            8'h24: return m_stat;
            8'h30: return m_rfsh;
            8'h34: return m_pwr;
            8'h40: return m_bank[0];
            8'h44: return m_bank[1];
            8'h48: return m_bank[2];
            8'h4C: return m_bank[3];
            8'h80: return m_tim;
            8'h94: return m_eccc;
            8'h98: return m_eccs;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] o);
        case (o)
            8'h00, 8'h08: return "R3";
            8'h24: return "R5";
            8'h04, 8'h42: return "R11";
            default: return "R7";
        endcase
    endfunction

    task automatic model_wr(input logic [7:0] o, input logic [31:0] v);
        case (o)
            8'h00: m_err0 = m_err0 & ~v;
            8'h08: m_err1 = m_err1 & ~v;
            8'h10: m_eadr = v;
            8'h20: begin
                if (!m_cfg[31] && v[31]) m_stat[31] = 1'b0;
                if (m_cfg[31] && !v[31]) m_stat[31] = 1'b1;
                m_stat[30] = v[30];
                m_cfg = v;
            end
            8'h30: m_rfsh = v & 32'h3FF8_0000;
            8'h34: m_pwr = (v & 32'hF800_0000) | 32'h07C0_0000;
            8'h40: m_bank[0] = v & 32'hFFDE_E001;
            8'h44: m_bank[1] = v & 32'hFFDE_E001;
            8'h48: m_bank[2] = v & 32'hFFDE_E001;
            8'h4C: m_bank[3] = v & 32'hFFDE_E001;
            8'h80: m_tim = v & 32'h018F_C01F;
            8'h94: m_eccc = v & 32'h00F0_0000;
            8'h98: begin m_eccs = v; m_irq = (v != 0); end
            default: ;
        endcase
    endtask

    task automatic set_ofs(input logic [7:0] o);
        @(negedge clk);
        ofs_we = 1; ofs_wdata = o;
        @(negedge clk);
        ofs_we = 0;
    endtask

    task automatic wr(input logic [7:0] o, input logic [31:0] v);
        set_ofs(o);
        dat_we = 1; dat_wdata = v;
        @(negedge clk);
        dat_we = 0;
        model_wr(o, v);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] o);
        set_ofs(o);
        #2;
        chk(req, dat_rdata, exp_rd(o));
    endtask

    function automatic logic [31:0] exp_size(input logic [31:0] b);
        if (b[19:17] == 3'd7) return 32'h0;
        return 32'h0040_0000 << b[19:17];
    endfunction

    task automatic chk_banks(input logic [31:0] a);
        mem_addr = a;
        #2;
        for (int i = 0; i < NB; i++) begin
            logic [31:0] bs, sz;
            logic on, h;
            bs = m_bank[i] & 32'hFF80_0000;
            sz = exp_size(m_bank[i]);
            on = m_cfg[31] & m_bank[i][0];
            h  = on && (a >= bs) && ((a - bs) < sz);
            chk("R8 base", bank_base[i], bs);
            chk("R8 size", bank_size[i], sz);
            chk("R8 on", 32'(bank_on[i]), 32'(on));
            chk("R9 hit", 32'(bank_hit[i]), 32'(h));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; ofs_we = 0; ofs_wdata = 0; dat_we = 0; dat_wdata = 0;
        err_set0 = 0; err_set1 = 0; mem_addr = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R2: reset values on every offset
        for (int i = 0; i < 16; i++) rd_chk("R2", ofs_list[i]);
        chk("R2 irq", 32'(ecc_irq), 32'h0);

        // R3: hardware set, software clear, set wins on collision
        @(negedge clk); err_set0 = 32'h0000_00F3; err_set1 = 32'h8000_0001;
        @(negedge clk); err_set0 = 0; err_set1 = 0;
        m_err0 = 32'h0000_00F3; m_err1 = 32'h8000_0001;
        rd_chk("R3 set0", 8'h00);
        rd_chk("R3 set1", 8'h08);
        wr(8'h00, 32'h0000_0031);
        rd_chk("R3 clear", 8'h00);
        set_ofs(8'h08);
        dat_we = 1; dat_wdata = 32'hFFFF_FFFF; err_set1 = 32'h0000_0004;
        @(negedge clk);
        dat_we = 0; err_set1 = 0;
        m_err1 = 32'h0000_0004;
        #2 chk("R3 set wins", dat_rdata, m_err1);

        // R1: write lands at latched offset only; offset persists across reads
        wr(8'h10, 32'hDEAD_BEEF);
        #2 chk("R1 readback same offset", dat_rdata, 32'hDEAD_BEEF);
        rd_chk("R1 neighbour", 8'h20);

        // R4: status ignores writes
        wr(8'h24, 32'hFFFF_FFFF);
        rd_chk("R4", 8'h24);

        // R5/R6: enable edges and self-refresh mirror
        wr(8'h20, 32'hC000_0000);
        rd_chk("R5 rise", 8'h24);
        wr(8'h20, 32'h0000_0000);
        rd_chk("R5 fall", 8'h24);
        wr(8'h20, 32'h4000_0000);
        rd_chk("R6 follow", 8'h24);

        // R10: interrupt edges
        wr(8'h98, 32'h0000_0100);
        chk("R10 rise", 32'(ecc_irq), 32'h1);
        wr(8'h98, 32'h0);
        chk("R10 fall", 32'(ecc_irq), 32'h0);

        // R11: unassigned write leaves everything alone
        wr(8'h04, 32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) rd_chk("R11 sweep", ofs_list[i]);

        // R8/R9: directed banks, boundary probes
        wr(8'h40, 32'h0080_0001);          // 8 MiB at 0x00800000, size 4 MiB
        wr(8'h44, 32'h1000_0000 | (32'd6 << 17) | 1); // 256 MiB
        wr(8'h48, 32'h4000_0000 | (32'd7 << 17) | 1); // invalid size
        wr(8'h4C, 32'h8000_0000 | (32'd2 << 17));     // not valid
        chk_banks(32'h0080_0000);          // disabled controller
        wr(8'h20, 32'h8000_0000);
        chk_banks(32'h0080_0000);
        chk_banks(32'h007F_FFFF);
        chk_banks(32'h00BF_FFFF);
        chk_banks(32'h00C0_0000);
        chk_banks(32'h1FFF_FFFF);
        chk_banks(32'h2000_0000);
        chk_banks(32'h4000_0000);
        chk_banks(32'h8000_0000);

        // Random mixed traffic
        for (int it = 0; it < 400; it++) begin
            logic [7:0]  o;
            logic [31:0] v;
            int b;
            o = ofs_list[$urandom_range(0, 15)];
            v = $urandom();
            if (o == 8'h98 && v[0]) v = 0;
            wr(o, v);
            #2 chk(req_of(o), dat_rdata, exp_rd(o));
            chk("R10 level", 32'(ecc_irq), 32'(m_irq));
            b = $urandom_range(0, NB - 1);
            case ($urandom_range(0, 4))
                0: chk_banks(m_bank[b] & 32'hFF80_0000);
                1: chk_banks((m_bank[b] & 32'hFF80_0000) - 1);
                2: chk_banks((m_bank[b] & 32'hFF80_0000) + exp_size(m_bank[b]) - 1);
                3: chk_banks((m_bank[b] & 32'hFF80_0000) + exp_size(m_bank[b]));
                default: chk_banks($urandom());
            endcase
        end
        for (int i = 0; i < 16; i++) rd_chk("R1 final sweep", ofs_list[i]);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule